// File: doc/BRIEF.md
# Register-mapped SPI master controller

This block is an SPI master that a processor drives through four word-wide registers: two control words, a status word and a data port. A single-word transmit buffer feeds the shift register, and a single-word receive buffer takes each completed frame. There is no FIFO, so software or a DMA engine keeps the link running by watching the transmit-empty and receive-not-empty flags.

Frames are 8 or 16 bits long and go out MSB first or LSB first. Any of the four clock polarity and phase combinations can be selected. The serial clock comes from the system clock through a power-of-two divider. The block runs either in full duplex or in single-line bidirectional transmit, where the data line only drives and incoming bits are dropped. Slave select can follow a software-controlled bit. The block also provides a combined interrupt and two single-cycle DMA request strobes.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, all control bits read 0, the status word reads 0x0002 (only transmit-empty set), SCK is low, and irq is low.
- R2: Registers sit at word index 0 (control A), 1 (control B), 2 (status) and 3 (data), and a write and a read of data share index 3. In control A, only bits 0–9, 11, 14 and 15 are held (write mask 0xCBFF). In control B, only bits 0, 1, 5, 6 and 7 are held (mask 0x00E3). Other bits read 0.
- R3: Control A bits 5:3 hold a baud code B. SCK toggles every 2^B clocks, so one frame of N bits keeps the status busy bit (bit 7) high for exactly 2·N·2^B clock cycles.
- R4: Control A bit 11 selects 16-bit frames when set and 8-bit frames when clear. In 8-bit mode the upper byte of received data reads 0.
- R5: Control A bit 1 (CPOL) sets the SCK idle level. Control A bit 0 (CPHA) clear means MISO is sampled on the leading SCK edge of each bit; set means it is sampled on the trailing edge. MOSI changes on the other edge.
- R6: Control A bit 7 set sends and receives the least significant bit first. Clear means the most significant bit goes first.
- R7: Status bit 1 (transmit-empty) clears when the data port is written and sets when the buffer moves into the shift register. Status bit 0 (receive-not-empty) sets when a frame completes and clears when the data port is read.
- R8: Data written while a frame is shifting starts right after that frame's last SCK edge, and busy stays high across both frames.
- R9: A frame that completes while receive-not-empty is set raises status bit 6 (overrun). The receive buffer keeps its earlier contents.
- R10: Overrun clears only when a status read follows a data read. A status read on its own, or a data read on its own, leaves it set.
- R11: With control A bits 15 and 14 both set, line_oe is 1, MISO is ignored and received frames read as 0. With bit 15 set and bit 14 clear, line_oe is 0. With bit 15 clear, line_oe is 1.
- R12: irq is the OR of overrun & B bit 5, receive-not-empty & B bit 6 and transmit-empty & B bit 7. dma_rx_req and dma_tx_req pulse for one cycle when receive-not-empty & B bit 0 or transmit-empty & B bit 1 goes high.
- R13: The engine runs only when control A bit 6 (enable) and bit 2 (master) are both set. When the engine is idle or stopped, SCK sits at the CPOL level. ss_n follows control A bit 8 when bit 9 is set; otherwise ss_n is the inverse of the run condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on data and status) |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| line_oe | output | 1 | Output enable for the data line |
| ss_n | output | 1 | Slave select, active low |
| irq | output | 1 | Combined interrupt request |
| dma_tx_req | output | 1 | One-cycle transmit DMA request |
| dma_rx_req | output | 1 | One-cycle receive DMA request |

## Verification
The embedded properties watch the following on every cycle:
- SCK resting at the CPOL level whenever no frame is active.
- transmit-empty dropping after a data write.
- receive-not-empty dropping after a data read.
- A pending word starting the engine.
- The sticky overrun flag and the receive buffer staying unchanged when overrun rises.
- The DMA strobes lasting one cycle.

Other behaviour depends on whole frames, so only the bench scenarios can show it. A bench slave model recovers the shifted bit order and checks which edge samples for every polarity, phase, order and width. The scenarios also cover exact frame length in cycles for a given divider, the overlap of two back-to-back frames, and the ordered read sequence that clears overrun.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int BAUD_W = 3,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              line_oe,
  output logic              ss_n,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  timeunit 1ns; timeprecision 1ps;

  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = (1 << BAUD_W);
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam logic [ADDR_W-1:0] A_CA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DR = ADDR_W'(3);
  localparam logic [WORD_W-1:0] CA_MASK = WORD_W'(16'hCBFF);
  localparam logic [7:0]        CB_MASK = 8'hE3;

  logic [WORD_W-1:0] ca, tx_buf, sh, rxs, rx_buf, rx_nx, rx_cur;
  logic [7:0]        cb;
  logic              txe, rxne, ovr, arm, busy, ph;
  logic [CNT_W-1:0]  dcnt, half_m1;
  logic [EDGE_W-1:0] ecnt, last_idx;
  logic              dtx_q, drx_q;

  wire cpha = ca[0];
  wire cpol = ca[1];
  wire [BAUD_W-1:0] baud = ca[3 +: BAUD_W];
  wire lsb  = ca[7];
  wire f16  = ca[11];
  wire bidi_tx = ca[15] & ca[14];
  wire run  = ca[6] & ca[2];

  wire wr_dr = bus_wr & (bus_addr == A_DR);
  wire rd_dr = bus_rd & (bus_addr == A_DR);
  wire rd_st = bus_rd & (bus_addr == A_ST);

  assign half_m1  = (CNT_W'(1) << baud) - CNT_W'(1);
  assign last_idx = f16 ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(WORD_W - 1);

  wire tick  = busy & (dcnt == half_m1);
  wire last  = tick & (ecnt == last_idx);
  wire samp  = tick & (cpha ? ecnt[0] : ~ecnt[0]);
  wire shft  = tick & (cpha ? (~ecnt[0] & (ecnt != '0)) : ecnt[0]);
  wire start = run & ~txe & (~busy | last);
  wire rx_in = bidi_tx ? 1'b0 : miso;
  wire rxne_keep = rxne & ~rd_dr;

  always_comb begin
    if (lsb)
      rx_nx = f16 ? {rx_in, rxs[WORD_W-1:1]} : {{HALF_W{1'b0}}, rx_in, rxs[HALF_W-1:1]};
    else
      rx_nx = f16 ? {rxs[WORD_W-2:0], rx_in} : {{HALF_W{1'b0}}, rxs[HALF_W-2:0], rx_in};
    rx_cur = samp ? rx_nx : rxs;
  end

  assign sck     = cpol ^ ph;
  assign mosi    = lsb ? sh[0] : (f16 ? sh[WORD_W-1] : sh[HALF_W-1]);
  assign line_oe = ~ca[15] | ca[14];
  assign ss_n    = ca[9] ? ca[8] : ~run;
  assign irq     = (cb[5] & ovr) | (cb[6] & rxne) | (cb[7] & txe);

  wire dtx_c = cb[1] & txe;
  wire drx_c = cb[0] & rxne;
  assign dma_tx_req = dtx_c & ~dtx_q;
  assign dma_rx_req = drx_c & ~drx_q;

  always_comb begin
    case (bus_addr)
      A_CA:    bus_rdata = ca;
      A_CB:    bus_rdata = {{(WORD_W-8){1'b0}}, cb};
      A_ST:    bus_rdata = {{(WORD_W-8){1'b0}}, busy, ovr, 4'b0, txe, rxne};
      default: bus_rdata = rx_buf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca <= '0; cb <= '0; tx_buf <= '0; txe <= 1'b1; sh <= '0; rxs <= '0;
      rx_buf <= '0; rxne <= 1'b0; ovr <= 1'b0; arm <= 1'b0; busy <= 1'b0;
      ph <= 1'b0; dcnt <= '0; ecnt <= '0; dtx_q <= 1'b0; drx_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CA) ca <= bus_wdata & CA_MASK;
      if (bus_wr && bus_addr == A_CB) cb <= bus_wdata[7:0] & CB_MASK;
      if (wr_dr) tx_buf <= bus_wdata;

      if (wr_dr)      txe <= 1'b0;
      else if (start) txe <= 1'b1;

      if (!run) begin
        busy <= 1'b0; ph <= 1'b0; dcnt <= '0; ecnt <= '0;
      end else if (start) begin
        sh   <= f16 ? tx_buf : {{HALF_W{1'b0}}, tx_buf[HALF_W-1:0]};
        rxs  <= '0;
        busy <= 1'b1; ph <= 1'b0; dcnt <= '0; ecnt <= '0;
      end else if (last) begin
        busy <= 1'b0; ph <= 1'b0; dcnt <= '0; ecnt <= '0;
      end else if (tick) begin
        dcnt <= '0;
        ph   <= ~ph;
        ecnt <= ecnt + EDGE_W'(1);
        if (shft) sh <= lsb ? (sh >> 1) : (sh << 1);
        if (samp) rxs <= rx_nx;
      end else if (busy) begin
        dcnt <= dcnt + CNT_W'(1);
      end

      if (last && run) begin
        if (rxne_keep) begin
          ovr <= 1'b1; arm <= 1'b0;
        end else begin
          rx_buf <= rx_cur; rxne <= 1'b1;
        end
      end else if (rd_dr) begin
        rxne <= 1'b0;
      end

      if (!(last && run && rxne_keep)) begin
        if (rd_st && arm) begin
          ovr <= 1'b0; arm <= 1'b0;
        end else if (rd_dr && ovr) begin
          arm <= 1'b1;
        end
      end

      dtx_q <= dtx_c;
      drx_q <= drx_c;
    end
  end

  p_sck_rest_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
  p_txe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dr |=> !txe);
  p_rxne_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dr && !last) |=> !rxne);
  p_pending_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !txe && !busy) |=> busy);
  p_ovr_keeps_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rx_buf));
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_st) |=> ovr);
  p_dma_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_req |=> !dma_tx_req) and (dma_rx_req |=> !dma_rx_req));
endmodule

// File: tb/sim_spi_master_regs.sv
module sim_spi_master_regs;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0, bus_rdata;
  logic sck, mosi, line_oe, ss_n, irq, dma_tx_req, dma_rx_req;
  logic miso = 1'b0;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  bit s_sync = 1'b1, s_cpha = 1'b0, s_lsb = 1'b0, s_f16 = 1'b0;
  logic s_prev = 1'b0;
  int s_e = 0;
  logic [15:0] s_word = 16'h0, s_next = 16'h0, s_cap = 16'h0;
  int n_rxdma = 0;

  spi_master_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .line_oe(line_oe), .ss_n(ss_n),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    int nb, k, idx;
    nb = s_f16 ? 16 : 8;
    if (dma_rx_req) n_rxdma++;
    if (s_sync) begin
      s_prev = sck; s_e = 0;
    end else if (sck !== s_prev) begin
      s_prev = sck;
      s_e++;
      k = (s_e - 1) / 2;
      if ((s_e % 2 == 1) != s_cpha) s_cap[s_lsb ? k : nb - 1 - k] = mosi;
      if (s_e == 2 * nb) begin s_e = 0; s_word = s_next; end
    end
    idx = s_cpha ? ((s_e == 0) ? 0 : (s_e - 1) / 2) : s_e / 2;
    miso = s_word[s_lsb ? idx : nb - 1 - idx];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg(input bit cpha, input bit cpol, input bit lsb, input bit f16,
                     input int br, input logic [15:0] extra);
    s_sync = 1'b1;
    s_cpha = cpha; s_lsb = lsb; s_f16 = f16; s_cap = 16'h0;
    wr(2'd0, 16'(cpha) | (16'(cpol) << 1) | 16'h0004 | (16'(br) << 3) | 16'h0040 |
             (16'(lsb) << 7) | (16'(f16) << 11) | extra);
    @(negedge clk);
    @(negedge clk);
    s_sync = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] tx, input logic [15:0] sw,
                      input logic [15:0] exp_rx, input int exp_cyc, input string tag);
    logic [15:0] v, rx, mask;
    int cyc, guard;
    mask = s_f16 ? 16'hFFFF : 16'h00FF;
    s_word = sw; s_next = sw;
    wr(2'd3, tx);
    rd(2'd2, v);
    cyc = 0; guard = 0;
    do begin
      rd(2'd2, v);
      if (v[7]) cyc++;
      guard++;
    end while (v[7] && guard < 5000);
    chk(cyc == exp_cyc, {tag, " R3 busy cycles"}, cyc, exp_cyc);
    chk(v[1:0] == 2'b11, {tag, " R7 flags at end"}, int'(v[1:0]), 3);
    rd(2'd3, rx);
    chk(rx == exp_rx, {tag, " R5 R6 R4 received word"}, rx, exp_rx);
    chk((s_cap & mask) == (tx & mask), {tag, " R5 R6 shifted word"}, s_cap & mask, tx & mask);
    rd(2'd2, v);
    chk(v[0] == 1'b0, {tag, " R7 rxne cleared by read"}, int'(v[0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, tx, sw, mask;
    int i, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd2, v); chk(v == 16'h0002, "R1 status at reset", v, 16'h0002);
    rd(2'd0, v); chk(v == 16'h0000, "R1 control A at reset", v, 0);
    chk(sck == 1'b0 && irq == 1'b0, "R1 sck and irq low", {sck, irq}, 0);

    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk(v == 16'hCBFF, "R2 control A mask", v, 16'hCBFF);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk(v == 16'h00E3, "R2 control B mask", v, 16'h00E3);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000);

    i = 0;
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int f = 0; f < 2; f++)
          for (int b = 0; b < 2; b++) begin
            cfg(m[0], m[1], o[0], f[0], b, 16'h0);
            chk(sck == m[1], "R13 idle sck at cpol", sck, m[1]);
            mask = f ? 16'hFFFF : 16'h00FF;
            tx = 16'h A5C3 ^ 16'(i * 16'h1357);
            sw = ~(tx ^ 16'(i * 16'h0F1D));
            xfer(tx, sw, sw & mask, 2 * (f ? 16 : 8) * (1 << b), "sweep");
            i++;
          end

    cfg(1'b0, 1'b0, 1'b0, 1'b0, 7, 16'h0);
    xfer(16'h003C, 16'h00C5, 16'h00C5, 2 * 8 * 128, "R3 widest divider");

    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h0);
    s_word = 16'h0096; s_next = 16'h0069;
    wr(2'd3, 16'h0011);
    rd(2'd2, v);
    rd(2'd2, v); chk(v[1] == 1'b1 && v[7] == 1'b1, "R7 txe set on load", v, 16'h0082);
    c = 1;
    wr(2'd3, 16'h0022); c++;
    rd(2'd2, v); chk(v[1] == 1'b0, "R7 txe cleared by write", v[1], 0);
    if (v[7]) c++;
    do begin rd(2'd2, v); if (v[7]) c++; end while (v[7] && c < 500);
    chk(c == 32, "R8 busy held over two frames", c, 32);
    chk(v[6] == 1'b1 && v[0] == 1'b1, "R9 overrun raised", v, 16'h0043);
    wr(2'd1, 16'h0020);
    chk(irq == 1'b1, "R12 error irq", irq, 1);
    rd(2'd2, v); chk(v[6] == 1'b1, "R10 status-only read keeps overrun", v[6], 1);
    rd(2'd3, v); chk(v == 16'h0096, "R9 buffer keeps first frame", v, 16'h0096);
    rd(2'd2, v); chk(v[6] == 1'b1 && v[0] == 1'b0, "R10 still set before status read", v, 16'h0042);
    rd(2'd2, v); chk(v[6] == 1'b0, "R10 cleared by data then status", v[6], 0);
    chk(irq == 1'b0, "R12 irq drops with overrun", irq, 0);
    chk(s_cap[7:0] == 8'h22, "R8 second frame shifted", s_cap[7:0], 16'h22);

    wr(2'd1, 16'h0080); chk(irq == 1'b1, "R12 txe irq", irq, 1);
    wr(2'd1, 16'h0040); chk(irq == 1'b0, "R12 rxne irq idle", irq, 0);
    wr(2'd1, 16'h0002); chk(dma_tx_req == 1'b1, "R12 tx dma strobe", dma_tx_req, 1);
    @(negedge clk); chk(dma_tx_req == 1'b0, "R12 tx dma one cycle", dma_tx_req, 0);
    wr(2'd1, 16'h0001);
    n_rxdma = 0;
    xfer(16'h005A, 16'h00A7, 16'h00A7, 16, "R12 rx dma");
    chk(n_rxdma == 1, "R12 rx dma pulses", n_rxdma, 1);
    wr(2'd1, 16'h0000);

    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0, 16'hC000);
    chk(line_oe == 1'b1, "R11 one-line transmit drives", line_oe, 1);
    xfer(16'h00B4, 16'h00FF, 16'h0000, 16, "R11 one-line transmit");
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h8000);
    chk(line_oe == 1'b0, "R11 direction input", line_oe, 0);
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h0);
    chk(line_oe == 1'b1 && ss_n == 1'b0, "R11 R13 full duplex oe and select", {line_oe, ss_n}, 2);

    cfg(1'b0, 1'b1, 1'b0, 1'b0, 0, 16'h0300);
    chk(ss_n == 1'b1 && sck == 1'b1, "R13 software select high, sck idle", {ss_n, sck}, 3);
    cfg(1'b0, 1'b1, 1'b0, 1'b0, 0, 16'h0200);
    chk(ss_n == 1'b0, "R13 software select low", ss_n, 0);
    wr(2'd0, 16'h0002);
    chk(sck == 1'b1 && ss_n == 1'b1, "R13 disabled sck at cpol", {sck, ss_n}, 3);
    wr(2'd3, 16'h00AA);
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 16'h0000, "R13 disabled engine holds word", v, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule